// File: doc/BRIEF.md
# Half-Bit Encoded Frame Transmitter

This block turns one 9-bit word into a framed serial burst on a single-ended data output. The output feeds an external differential line driver whose enable the block also drives, so the shared line is driven only while a frame is in progress. The low eight bits of the word are the payload. The top bit is a framing flag that decides the shape of the last symbol.

Every frame runs in a fixed order. First comes a settling interval with the driver enabled and the data held low. Then come a start symbol, eight payload symbols and the flag symbol, and finally a short low tail before the enable drops. Each symbol is two half-bit periods long. Every half-bit lasts `HALF_TICKS` bit-clock ticks, and one bit-clock tick is `CLK_DIV` system clocks.

Words arrive over a valid/ready handshake. A busy output covers the whole frame, so a companion receiver can ignore the line while this block is driving it.

Top module: `hbe_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is running, `drv_en_o`, `line_data_o` and `busy_o` are 0 and `word_ready_o` is 1.
- R2: A word is taken at a rising edge where `word_valid_i` and `word_ready_o` are both 1. From the next cycle, `drv_en_o` and `busy_o` are 1 and `line_data_o` stays 0 for `SETTLE_TICKS*CLK_DIV` cycles.
- R3: The start symbol follows the settling interval. It is high for one half-bit (`HALF_TICKS*CLK_DIV` cycles) and then low for one half-bit.
- R4: The payload bits `word[7:0]` are sent least-significant bit first. Bit i takes half-bit slots 2+2i and 3+2i, counting the start symbol's halves as slots 0 and 1.
- R5: Each payload bit is sent as its complement in the first half-bit and as its true value in the second half-bit.
- R6: The flag symbol takes slots 18 and 19. Its first half equals `word[8]`, and its second half is always 0.
- R7: After the flag symbol, `line_data_o` stays 0 with `drv_en_o` still 1 for `TAIL_TICKS*CLK_DIV` cycles. Then `drv_en_o` and `busy_o` drop together.
- R8: `word_ready_o` is 0 whenever `busy_o` is 1. A word held valid during a frame is not lost: it is taken at the first edge after busy falls, and its frame follows with correct contents.
- R9: Asserting `rst_ni` low during a frame at once forces `drv_en_o`, `line_data_o` and `busy_o` to 0 and `word_ready_o` to 1. The block then stays idle until a new word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | A word is offered |
| word_data_i | input | DATA_BITS+1 | Payload in the low bits, framing flag in the top bit |
| word_ready_o | output | 1 | The block can take a word |
| line_data_o | output | 1 | Serial data to the line driver |
| drv_en_o | output | 1 | Line driver enable |
| busy_o | output | 1 | A frame is in progress (receiver lockout) |

## Verification
Let k be the number of whole cycles after the accepting edge. The outputs switch to the first settling value at k = 0. The start symbol begins at k = `SETTLE_TICKS*CLK_DIV`, and every later half-bit starts `HALF_TICKS*CLK_DIV` cycles after the previous one. Enable and busy fall at k = `CLK_DIV*(SETTLE_TICKS+20*HALF_TICKS+TAIL_TICKS)`.

The bench applies words on falling edges and compares all four outputs at every falling edge against a value computed from k alone. Each sample therefore falls mid-cycle, after all registers on the path have settled. Reset is asynchronous, so its effect is checked one time unit after `rst_ni` falls, with no clock edge in between.

// File: rtl/hbe_pkg.sv
package hbe_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_START,
    PH_DATA,
    PH_FLAG,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/hbe_tick_gen.sv
module hbe_tick_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CNT_W = $clog2(CLK_DIV);
      logic [CNT_W-1:0] cnt_q;
      assign tick_o = run_i && (cnt_q == CNT_W'(CLK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (!run_i)  cnt_q <= '0;  // phase-align divider to word acceptance
        else if (tick_o)  cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/hbe_seq.sv
module hbe_seq
  import hbe_pkg::*;
#(
  parameter int DATA_BITS    = 8,
  parameter int SETTLE_TICKS = 32,
  parameter int HALF_TICKS   = 4,
  parameter int TAIL_TICKS   = 4,
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic             second_half_o,
  output logic [IDX_W-1:0] bit_idx_o
);
  localparam int MAX_LEN = (SETTLE_TICKS > HALF_TICKS)
                         ? ((SETTLE_TICKS > TAIL_TICKS) ? SETTLE_TICKS : TAIL_TICKS)
                         : ((HALF_TICKS > TAIL_TICKS) ? HALF_TICKS : TAIL_TICKS);
  localparam int CNT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  phase_e           phase_q;
  logic             half_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] seg_last;
  logic             seg_done;

  always_comb begin
    unique case (phase_q)
      PH_SETTLE: seg_last = CNT_W'(SETTLE_TICKS - 1);
      PH_TAIL:   seg_last = CNT_W'(TAIL_TICKS - 1);
      default:   seg_last = CNT_W'(HALF_TICKS - 1);
    endcase
  end

  assign seg_done = tick_i && (cnt_q == seg_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      half_q  <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else if (phase_q == PH_IDLE) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      idx_q  <= '0;
      if (start_i) phase_q <= PH_SETTLE;
    end else if (seg_done) begin
      cnt_q <= '0;
      unique case (phase_q)
        PH_SETTLE: begin
          phase_q <= PH_START;
          half_q  <= 1'b0;
        end
        PH_START: begin
          half_q <= ~half_q;
          if (half_q) begin
            phase_q <= PH_DATA;
            idx_q   <= '0;
          end
        end
        PH_DATA: begin
          half_q <= ~half_q;
          if (half_q) begin
            if (idx_q == IDX_W'(DATA_BITS - 1)) phase_q <= PH_FLAG;
            else                                 idx_q   <= idx_q + 1'b1;
          end
        end
        PH_FLAG: begin
          half_q <= ~half_q;
          if (half_q) phase_q <= PH_TAIL;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o       = phase_q;
  assign second_half_o = half_q;
  assign bit_idx_o     = idx_q;
endmodule

// File: rtl/hbe_sym_enc.sv
module hbe_sym_enc
  import hbe_pkg::*;
#(
  parameter int DATA_BITS = 8,
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1
) (
  input  phase_e           phase_i,
  input  logic             second_half_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic [DATA_BITS:0] word_i,
  output logic             level_o
);
  logic cur_bit;
  assign cur_bit = word_i[bit_idx_i];

  always_comb begin
    unique case (phase_i)
      PH_START: level_o = ~second_half_i;
      PH_DATA:  level_o = second_half_i ? cur_bit : ~cur_bit;
      PH_FLAG:  level_o = second_half_i ? 1'b0 : word_i[DATA_BITS];
      default:  level_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hbe_frame_tx.sv
module hbe_frame_tx
  import hbe_pkg::*;
#(
  parameter int DATA_BITS    = 8,
  parameter int CLK_DIV      = 2,
  parameter int SETTLE_TICKS = 32,
  parameter int HALF_TICKS   = 4,
  parameter int TAIL_TICKS   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_valid_i,
  input  logic [DATA_BITS:0] word_data_i,
  output logic               word_ready_o,
  output logic               line_data_o,
  output logic               drv_en_o,
  output logic               busy_o
);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  phase_e             phase;
  logic               second_half;
  logic [IDX_W-1:0]   bit_idx;
  logic               tick;
  logic               accept;
  logic               active;
  logic [DATA_BITS:0] word_q;

  assign active = (phase != PH_IDLE);
  assign accept = word_valid_i && !active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (accept) word_q <= word_data_i;
  end

  hbe_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (active),
    .tick_o (tick)
  );

  hbe_seq #(
    .DATA_BITS    (DATA_BITS),
    .SETTLE_TICKS (SETTLE_TICKS),
    .HALF_TICKS   (HALF_TICKS),
    .TAIL_TICKS   (TAIL_TICKS)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (accept),
    .tick_i        (tick),
    .phase_o       (phase),
    .second_half_o (second_half),
    .bit_idx_o     (bit_idx)
  );

  hbe_sym_enc #(.DATA_BITS(DATA_BITS)) u_enc (
    .phase_i       (phase),
    .second_half_i (second_half),
    .bit_idx_i     (bit_idx),
    .word_i        (word_q),
    .level_o       (line_data_o)
  );

  assign drv_en_o     = active;
  assign busy_o       = active;
  assign word_ready_o = !active;
endmodule

// File: rtl/hbe_frame_tx_chk.sv
module hbe_frame_tx_chk #(
  parameter int HALF_CYC = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic word_valid_i,
  input logic word_ready_o,
  input logic line_data_o,
  input logic drv_en_o,
  input logic busy_o
);
  localparam int RUN_W = $clog2(HALF_CYC + 1) + 1;

  logic             prev_d;
  logic             prev_en;
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_d  <= 1'b0;
      prev_en <= 1'b0;
      run_len <= '0;
    end else begin
      prev_d  <= line_data_o;
      prev_en <= drv_en_o;
      if (line_data_o != prev_d)        run_len <= RUN_W'(1);
      else if (run_len < RUN_W'(HALF_CYC)) run_len <= run_len + 1'b1;
    end
  end

  p_release_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_o |-> !line_data_o);

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && word_ready_o) |=> (drv_en_o && busy_o && !line_data_o));

  p_rise_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> !line_data_o);

  p_no_ready_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !word_ready_o);

  p_end_together_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !drv_en_o);

  // R5: no level on the line is shorter than one half-bit while driven
  p_half_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && prev_en && (line_data_o != prev_d)) |-> (run_len >= RUN_W'(HALF_CYC)));
endmodule

bind hbe_frame_tx hbe_frame_tx_chk #(.HALF_CYC(CLK_DIV * HALF_TICKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .word_ready_o (word_ready_o),
  .line_data_o  (line_data_o),
  .drv_en_o     (drv_en_o),
  .busy_o       (busy_o)
);

// File: tb/hbe_frame_tx_tb.sv
module hbe_frame_tx_tb;
  localparam int D  = 2;
  localparam int S  = 32;
  localparam int H  = 4;
  localparam int T  = 4;
  localparam int HD = H * D;
  localparam int SD = S * D;
  localparam int F  = D * (S + 20 * H + T);
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{9'h1A5, 9'h05A, 9'h000, 9'h1FF, 9'h101, 9'h080};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [8:0] wdata = '0;
  logic       ready, ldata, den, busy;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  hbe_frame_tx #(
    .DATA_BITS(8), .CLK_DIV(D), .SETTLE_TICKS(S), .HALF_TICKS(H), .TAIL_TICKS(T)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(valid), .word_data_i(wdata),
    .word_ready_o(ready), .line_data_o(ldata), .drv_en_o(den), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_data(input logic [8:0] w, input int k);
    int r, h, sym, hf;
    if (k < SD) return 1'b0;
    r = k - SD;
    if (r >= 20 * HD) return 1'b0;
    h = r / HD; sym = h / 2; hf = h % 2;
    if (sym == 0) return (hf == 0);
    if (sym <= 8) return (hf == 0) ? ~w[sym-1] : w[sym-1];
    return (hf == 0) ? w[8] : 1'b0;
  endfunction

  function automatic string exp_tag(input int k);
    if (k < SD)            return "R2";
    if (k < SD + 2 * HD)   return "R3";
    if (k < SD + 18 * HD)  return "R4/R5";
    if (k < SD + 20 * HD)  return "R6";
    return "R7";
  endfunction

  // Caller sits at the falling edge of cycle k=0 after the accepting edge.
  task automatic check_frame(input logic [8:0] w, input int n);
    for (int k = 0; k < n; k++) begin
      logic act = (k < F);
      check(ldata == exp_data(w, k), exp_tag(k), $sformatf("data w=%h k=%0d", w, k),
            ldata, exp_data(w, k));
      check(den == act, (k < F) ? "R2" : "R7", $sformatf("drv_en k=%0d", k), den, act);
      check(busy == act, (k < F) ? "R2" : "R7", $sformatf("busy k=%0d", k), busy, act);
      check(ready == !act, "R8", $sformatf("ready k=%0d", k), ready, !act);
      @(negedge clk);
    end
  endtask

  task automatic check_idle(input string req);
    check(!den, req, "drv_en idle", den, 0);
    check(!ldata, req, "data idle", ldata, 0);
    check(!busy, req, "busy idle", busy, 0);
    check(ready, req, "ready idle", ready, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1;
    check_idle("R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    // Table walk: one frame per word
    for (int i = 0; i < NV; i++) begin
      valid = 1'b1; wdata = VEC[i];
      @(negedge clk);
      valid = 1'b0; wdata = '0;
      check_frame(VEC[i], F + 1);
      check_idle("R1");
    end

    // R8: second word held during a frame is taken right after busy falls
    valid = 1'b1; wdata = 9'h1C3;
    @(negedge clk);
    wdata = 9'h03C;
    check_frame(9'h1C3, F + 1);
    valid = 1'b0; wdata = '0;
    check_frame(9'h03C, F + 1);
    check_idle("R8");

    // R9: asynchronous reset in mid-frame
    valid = 1'b1; wdata = 9'h1FF;
    @(negedge clk);
    valid = 1'b0;
    repeat (SD + 3 * HD) @(negedge clk);
    check(den, "R9", "drv_en before reset", den, 1);
    rst_n = 1'b0;
    #1;
    check_idle("R9");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (F) @(negedge clk);
    check_idle("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule